// File: doc/BRIEF.md
# Serial receiver with per-character error tags

This block turns an asynchronous serial line into a stream of tagged characters. A 16x oversampling tick paces it. It first checks for a start bit at mid-bit and then samples each data bit, an optional parity bit and the stop position once per bit time. The word length is programmable from five to eight bits, and parity can be turned off or set to odd or even.

Every finished character is stored in a small receive queue as a 12-bit word. That word holds the data byte along with overrun, break, parity and framing flags. A separate sticky status nibble collects those flags until a write strobe clears them. The queue reports empty and full. The queue can be cut down to a single holding slot.

The consumer watches `q_empty`, reads the head word on `q_head` and strobes `q_pop`. It can clear the sticky status at any time.

Top module: `rxtag_top`

## Requirements
- R1: A stored word is laid out as bit 11 overrun, bit 10 break, bit 9 parity error, bit 8 framing error, bits 7..0 data, with the first data bit on the line landing in bit 0.
- R2: `word_sel` picks the data length: 2'b00 five bits, 2'b01 six, 2'b10 seven, 2'b11 eight. Data bits above the chosen length read as zero.
- R3: With `par_on`=1 one parity bit follows the data. `par_even`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets bit 9. With `par_on`=0 no parity bit is sampled and bit 9 stays 0.
- R4: A low level at the stop position sets bit 8, unless the character is a break. Afterwards the receiver waits for the line to go high before it looks for a new start.
- R5: A line held low from the start bit through the stop position yields exactly one word with data 0, bit 10 set and bits 9 and 8 clear. No further word appears until the line returns high.
- R6: A character that completes while the queue is full is discarded and sets status bit 3. The next word that is stored carries bit 11 set.
- R7: The status nibble holds bit 3 overrun, bit 2 break, bit 1 parity, bit 0 framing. Each bit is sticky, and a `stat_clr` pulse clears all four.
- R8: With `q_deep`=1 the queue holds 16 words. With `q_deep`=0 it holds one word, so `q_full` rises as soon as one word is stored.
- R9: Characters are received only while both `en_all` and `en_rx` are 1.
- R10: A start bit that is high again at its mid-bit sample is treated as a glitch and produces no word.
- R11: `two_stop` has no effect on reception.
- R12: `q_head` shows the oldest word before it is popped. A pop while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| word_sel | input | 2 | Data length code |
| par_on | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 even, 0 odd parity |
| two_stop | input | 1 | Transmit-side stop count, ignored here |
| q_deep | input | 1 | 1 selects the 16-word queue, 0 a single slot |
| en_all | input | 1 | Global enable |
| en_rx | input | 1 | Receive enable |
| q_pop | input | 1 | Removes the head word |
| stat_clr | input | 1 | Clears the sticky status |
| q_head | output | 12 | Oldest stored word |
| q_empty | output | 1 | Queue holds no word |
| q_full | output | 1 | Queue cannot accept a word |
| rx_stat | output | 4 | Sticky error status |

## Verification
Each data length is tried with all-ones and sparse bytes. This shows that the length decode and the zeroing of the upper bits are separate effects. Parity is tried in both modes with a correct and with an inverted parity bit, so a swapped mode shows up as errors on good frames. A bad stop on a non-zero byte is set against an all-low line, which separates framing from break. A start pulse that is too short, frames sent while disabled, a single-slot queue and an overfilled deep queue then exercise the paths that must produce no word or a tagged one.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rx_state_e;
endpackage

// File: rtl/rxtag_sync.sv
module rxtag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/rxtag_deframer.sv
module rxtag_deframer
  import rxtag_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      enable,
  input  logic [1:0] word_sel,
  input  logic      par_on,
  input  logic      par_even,
  output logic      done,
  output rx_entry_t entry
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [2:0]    idx, idx_n;
  logic [7:0]    sh, sh_n;
  logic          pbit, pbit_n;
  logic          brk_c;
  logic [2:0]    last_idx;

  assign last_idx = 3'd4 + {1'b0, word_sel};

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    idx_n   = idx;
    sh_n    = sh;
    pbit_n  = pbit;
    done    = 1'b0;
    brk_c   = 1'b0;
    entry   = '0;
    if (!enable) begin
      state_n = ST_IDLE;
    end else if (state == ST_WAITHI) begin
      if (rxd) state_n = ST_IDLE;
    end else if (tick) begin
      case (state)
        ST_IDLE: if (!rxd) begin
          state_n = ST_START;
          cnt_n   = '0;
        end
        ST_START: if (cnt == MID) begin
          if (!rxd) begin
            state_n = ST_DATA;
            cnt_n   = '0;
            idx_n   = '0;
            sh_n    = '0;
          end else begin
            state_n = ST_IDLE;
          end
        end else cnt_n = cnt + 1'b1;
        ST_DATA: if (cnt == LAST) begin
          cnt_n   = '0;
          sh_n[idx] = rxd;
          if (idx == last_idx) state_n = par_on ? ST_PAR : ST_STOP;
          else                 idx_n   = idx + 1'b1;
        end else cnt_n = cnt + 1'b1;
        ST_PAR: if (cnt == LAST) begin
          cnt_n   = '0;
          pbit_n  = rxd;
          state_n = ST_STOP;
        end else cnt_n = cnt + 1'b1;
        ST_STOP: if (cnt == LAST) begin
          done       = 1'b1;
          brk_c      = (sh == 8'h00) && (!par_on || !pbit) && !rxd;
          entry.brk  = brk_c;
          entry.frm  = !rxd && !brk_c;
          entry.par  = par_on && !brk_c && ((^sh) ^ pbit ^ ~par_even);
          entry.data = sh;
          state_n    = rxd ? ST_IDLE : ST_WAITHI;
        end else cnt_n = cnt + 1'b1;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      idx   <= idx_n;
      sh    <= sh_n;
      pbit  <= pbit_n;
    end
  end
endmodule

// File: rtl/rxtag_fifo.sv
module rxtag_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         deep,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, wptr_n, rptr, rptr_n;
  logic [AW:0]   count, count_n;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = deep ? (count == (AW+1)'(DEPTH)) : !empty;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_comb begin
    wptr_n  = do_push ? wptr + 1'b1 : wptr;
    rptr_n  = do_pop  ? rptr + 1'b1 : rptr;
    count_n = count;
    if (do_push && !do_pop)      count_n = count + 1'b1;
    else if (do_pop && !do_push) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end
endmodule

// File: rtl/rxtag_top.sv
module rxtag_top
  import rxtag_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd,
  input  logic        os_tick,
  input  logic [1:0]  word_sel,
  input  logic        par_on,
  input  logic        par_even,
  input  logic        two_stop,
  input  logic        q_deep,
  input  logic        en_all,
  input  logic        en_rx,
  input  logic        q_pop,
  input  logic        stat_clr,
  output logic [11:0] q_head,
  output logic        q_empty,
  output logic        q_full,
  output logic [3:0]  rx_stat
);
  logic      rxd_s;
  logic      char_done;
  rx_entry_t char_ent, store_ent;
  logic      ovr_pend, ovr_pend_n;
  logic [3:0] stat_n;
  logic      push, drop;
  logic      unused_two_stop;

  assign unused_two_stop = two_stop;

  rxtag_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  rxtag_deframer #(.OSR(OSR)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd_s),
    .enable(en_all && en_rx), .word_sel(word_sel), .par_on(par_on),
    .par_even(par_even), .done(char_done), .entry(char_ent)
  );

  assign push = char_done && !q_full;
  assign drop = char_done && q_full;

  always_comb begin
    store_ent     = char_ent;
    store_ent.ovr = ovr_pend;
    ovr_pend_n    = drop ? 1'b1 : (push ? 1'b0 : ovr_pend);
    stat_n        = stat_clr ? 4'b0 : rx_stat;
    if (char_done)
      stat_n = stat_n | {drop, char_ent.brk, char_ent.par, char_ent.frm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pend <= 1'b0;
      rx_stat  <= 4'b0;
    end else begin
      ovr_pend <= ovr_pend_n;
      rx_stat  <= stat_n;
    end
  end

  rxtag_fifo #(.DEPTH(DEPTH), .W(12)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(store_ent),
    .pop(q_pop), .deep(q_deep), .rdata(q_head),
    .empty(q_empty), .full(q_full)
  );
endmodule

// File: rtl/rxtag_chk.sv
module rxtag_chk
  import rxtag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       stat_clr,
  input logic       q_deep,
  input logic       q_pop,
  input logic       q_empty,
  input logic       q_full,
  input logic [3:0] rx_stat,
  input logic       en_all,
  input logic       en_rx,
  input logic [1:0] word_sel,
  input logic       char_done,
  input rx_entry_t  char_ent
);
  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((rx_stat & $past(rx_stat)) == $past(rx_stat)));
  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !char_done) |=> (rx_stat == 4'b0));
  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));
  // R8
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_deep && !q_empty) |-> q_full);
  // R5
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && char_ent.brk) |-> (char_ent.data == 8'h00 && !char_ent.frm));
  // R2
  short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && word_sel == 2'b00) |-> (char_ent.data[7:5] == 3'b000));
  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_all || !en_rx) |-> !char_done);
  // R12
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_empty && !char_done) |=> q_empty);
endmodule

bind rxtag_top rxtag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .q_deep(q_deep),
  .q_pop(q_pop), .q_empty(q_empty), .q_full(q_full), .rx_stat(rx_stat),
  .en_all(en_all), .en_rx(en_rx), .word_sel(word_sel),
  .char_done(char_done), .char_ent(char_ent)
);

// File: tb/rxtag_top_test.sv
module rxtag_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, os_tick = 1'b0;
  logic [1:0] word_sel = 2'b11;
  logic par_on = 1'b0, par_even = 1'b0, two_stop = 1'b0, q_deep = 1'b1;
  logic en_all = 1'b1, en_rx = 1'b1, q_pop = 1'b0, stat_clr = 1'b0;
  logic [11:0] q_head;
  logic q_empty, q_full;
  logic [3:0] rx_stat;

  int n_chk = 0, n_err = 0;
  bit mon_on = 1'b0;
  logic [11:0] expq[$];
  string tagq[$];

  rxtag_top uut (.*);

  always #4 clk = ~clk;

  initial begin
    @(posedge rst_n);
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_time();
    repeat (64) @(negedge clk);
  endtask

  // Scoreboard monitor: compares the head word, then pops it
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && !q_empty) begin
        if (expq.size() == 0) begin
          check(1'b0, "R12 unexpected word", q_head, 0);
        end else begin
          automatic logic [11:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          check(q_head == e, t, q_head, e);
        end
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
      end
    end
  end

  task automatic send_char(input logic [7:0] d, input bit flip, input bit bad_stop,
                           input bit store, input bit ovr, input string req);
    int nb = 5 + word_sel;
    logic [7:0] md = d & 8'((1 << nb) - 1);
    logic p = (^md) ^ ~par_even ^ flip;
    logic brk = (md == 0) && (!par_on || !p) && bad_stop;
    if (store) begin
      expq.push_back({ovr, brk, par_on && flip && !brk, bad_stop && !brk, brk ? 8'h00 : md});
      tagq.push_back(req);
    end
    rxd = 1'b0; bit_time();
    for (int i = 0; i < nb; i++) begin rxd = md[i]; bit_time(); end
    if (par_on) begin rxd = p; bit_time(); end
    rxd = !bad_stop; bit_time();
    rxd = 1'b1; bit_time(); bit_time();
  endtask

  task automatic clear_stat();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0; @(negedge clk);
  endtask

  task automatic drain();
    wait (expq.size() == 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(q_empty == 1'b1, "R8 reset empty", q_empty, 1);
    check(q_full == 1'b0, "R8 reset full", q_full, 0);
    check(rx_stat == 4'h0, "R7 reset status", rx_stat, 0);
    mon_on = 1'b1;

    // R1 eight-bit words, bit order and layout
    send_char(8'hA5, 0, 0, 1, 0, "R1 word A5");
    send_char(8'h3C, 0, 0, 1, 0, "R1 word 3C");
    // R2 all lengths
    word_sel = 2'b00; send_char(8'hFF, 0, 0, 1, 0, "R2 five bits");
    word_sel = 2'b01; send_char(8'hFF, 0, 0, 1, 0, "R2 six bits");
    word_sel = 2'b10; send_char(8'h81, 0, 0, 1, 0, "R2 seven bits");
    word_sel = 2'b11;
    drain();
    check(rx_stat == 4'h0, "R7 no flags on clean frames", rx_stat, 0);

    // R3 parity both modes
    par_on = 1'b1; par_even = 1'b1;
    send_char(8'h96, 0, 0, 1, 0, "R3 even good");
    send_char(8'h96, 1, 0, 1, 0, "R3 even bad");
    par_even = 1'b0;
    send_char(8'h07, 0, 0, 1, 0, "R3 odd good");
    send_char(8'h07, 1, 0, 1, 0, "R3 odd bad");
    par_on = 1'b0;
    drain();
    check(rx_stat == 4'b0010, "R7 parity sticky", rx_stat, 4'b0010);
    clear_stat();
    check(rx_stat == 4'h0, "R7 clear", rx_stat, 0);

    // R4 framing
    send_char(8'h55, 0, 1, 1, 0, "R4 bad stop");
    send_char(8'h12, 0, 0, 1, 0, "R4 recovery");
    drain();
    check(rx_stat == 4'b0001, "R7 framing sticky", rx_stat, 4'b0001);
    clear_stat();

    // R5 break: low for the whole frame and beyond
    expq.push_back(12'h400); tagq.push_back("R5 break word");
    rxd = 1'b0;
    for (int i = 0; i < 14; i++) bit_time();
    rxd = 1'b1; bit_time(); bit_time();
    drain();
    check(rx_stat == 4'b0100, "R5 break status", rx_stat, 4'b0100);
    clear_stat();

    // R11 two_stop has no effect
    two_stop = 1'b1;
    send_char(8'hC3, 0, 0, 1, 0, "R11 two_stop ignored");
    two_stop = 1'b0;

    // R9 enables
    en_rx = 1'b0;
    send_char(8'h5A, 0, 0, 0, 0, "R9");
    check(q_empty == 1'b1, "R9 rx disabled", q_empty, 1);
    en_rx = 1'b1; en_all = 1'b0;
    send_char(8'h5A, 0, 0, 0, 0, "R9");
    check(q_empty == 1'b1, "R9 global disabled", q_empty, 1);
    en_all = 1'b1;

    // R10 short start pulse
    rxd = 1'b0; repeat (16) @(negedge clk); rxd = 1'b1;
    bit_time(); bit_time();
    check(q_empty == 1'b1, "R10 glitch ignored", q_empty, 1);
    send_char(8'h69, 0, 0, 1, 0, "R10 after glitch");
    drain();

    // R12 pop on empty
    mon_on = 1'b0;
    q_pop = 1'b1; @(negedge clk); q_pop = 1'b0; @(negedge clk);
    check(q_empty == 1'b1, "R12 pop on empty", q_empty, 1);

    // R6 / R8 overrun of the deep queue
    for (int i = 0; i < 16; i++) send_char(8'(i * 7 + 1), 0, 0, 1, 0, "R8 deep fill");
    check(q_full == 1'b1, "R8 deep full after 16", q_full, 1);
    check(q_head == 12'h001, "R12 head shows oldest", q_head, 12'h001);
    send_char(8'hEE, 0, 0, 0, 0, "R6");
    check(rx_stat[3] == 1'b1, "R6 overrun status", rx_stat, 4'b1000);
    mon_on = 1'b1;
    drain();
    send_char(8'h44, 0, 0, 1, 1, "R6 overrun tag");
    drain();
    clear_stat();

    // R8 single slot
    mon_on = 1'b0; q_deep = 1'b0;
    send_char(8'h21, 0, 0, 1, 0, "R8 one slot word");
    check(q_full == 1'b1, "R8 one slot full", q_full, 1);
    check(q_empty == 1'b0, "R8 one slot not empty", q_empty, 0);
    send_char(8'h22, 0, 0, 0, 0, "R6");
    check(rx_stat == 4'b1000, "R6 one slot overrun", rx_stat, 4'b1000);
    mon_on = 1'b1;
    drain();
    send_char(8'h23, 0, 0, 1, 1, "R6 one slot tag");
    drain();

    check(expq.size() == 0, "R1 all words seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule